// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block is the send side of one processor's local interrupt controller. Software reaches it through a small memory-mapped register port. It holds the processor's own 8-bit ID, an enable bit with a spurious-interrupt vector, a write-only end-of-interrupt register, and a 64-bit interrupt command register split into a low and a high word. A write to the low command word launches an interprocessor message. The message carries a vector, a delivery mode, level and trigger attributes, and a recipient bit-mask with one bit per processor in the system. The width of that mask is set by `NUM_CPU`, and bit *i* stands for the processor whose ID is *i*.

The recipients come from a 2-bit shorthand in the low word. When the shorthand is zero, they come from the 8-bit destination held in the high word. Once launched, the message is presented on a valid/ready message port. The delivery-status bit in the low word reads 1 until the message port accepts the message. Software polls that bit before it issues the next command. Cluster-mode logical arbitration, lowest-priority arbitration and the receive path belong to other blocks.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset, every register reads zero and `msgValid`, `eoiPulse` and `busyError` are low.
- R2: The ID register at offset 0x020 stores bits 31:24 of a write and returns them in bits 31:24. All other bits read zero.
- R3: The register at offset 0x0F0 stores the unit-enable flag in bit 8 and the spurious vector in bits 7:0. All other bits read zero. When `FORCE_SPUR_LOW` is 1, bits 3:0 of the vector read as ones.
- R4: A write of any data to offset 0x0B0 drives `eoiPulse` high for exactly the one cycle after the write. Reads of 0x0B0 return zero.
- R5: When the unit is enabled and no message is pending, a write to the low command word at 0x300 with a legal delivery mode raises `msgValid` in the next cycle. The message then carries vector = bits 7:0, mode = bits 10:8, `msgLogical` = bit 11, `msgLevel` = bit 14 and `msgTrigger` = bit 15. Modes 011 and 111 are illegal.
- R6: Bit 12 of the low word reads 1 exactly while `msgValid` is high. The bit is cleared in the cycle after `msgValid` and `msgReady` are both high. Software writes to bit 12 have no effect.
- R7: Shorthand bits 19:18 = 01 make the recipient mask the single bit of the local ID. If the local ID is `NUM_CPU` or higher, the mask is empty.
- R8: Shorthand 10 sets every mask bit. Shorthand 11 sets every mask bit except the local ID's bit.
- R9: With shorthand 00 and bit 11 = 0 (physical), the mask depends on the destination in bits 31:24 of the high word at 0x310. If the destination is below `NUM_CPU`, only that bit is set. If it is 0xFF, all bits are set. Otherwise the mask is empty.
- R10: With shorthand 00 and bit 11 = 1 (logical), the mask equals the low `NUM_CPU` bits of the destination.
- R11: A low-word write while the unit is disabled, or with mode 011 or 111, raises no message and leaves the status idle. The written fields are still stored and read back.
- R12: A low-word write while a message is pending is ignored, so the stored fields and the message stay unchanged. It raises `busyError` for exactly the next cycle.
- R13: The message fields are captured at launch. A high-word write while a message is pending does not change `msgRecipients`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational, zero when no read |
| msgValid | output | 1 | Message pending on the message port |
| msgReady | input | 1 | Message port accepts the message |
| msgRecipients | output | NUM_CPU | Recipient bit-mask |
| msgVector | output | 8 | Message vector |
| msgMode | output | 3 | Delivery mode |
| msgLogical | output | 1 | Destination mode was logical |
| msgLevel | output | 1 | Level bit |
| msgTrigger | output | 1 | Trigger-mode bit |
| eoiPulse | output | 1 | One-cycle end-of-interrupt strobe |
| busyError | output | 1 | One-cycle flag for a command write dropped while busy |

## Verification
The assertions assume that a read strobe and a write strobe never target the same offset in the same cycle. They also assume that reset holds `regWrEn` low, so a one-cycle look back at the write strobe never sees an undriven value. The stimulus drives all register strobes from tasks that raise them for exactly one cycle between falling clock edges. It keeps `msgReady` low except while it hands off a message. This lets the tests observe the hold and stability of a pending message directly.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int DATA_W = 32;

  localparam int OFF_ID     = 'h020;
  localparam int OFF_EOI    = 'h0B0;
  localparam int OFF_SPUR   = 'h0F0;
  localparam int OFF_CMD_LO = 'h300;
  localparam int OFF_CMD_HI = 'h310;

  // readable bits of the low command word, status bit excluded
  localparam logic [DATA_W-1:0] CMD_LO_MASK = 32'h000C_CFFF;
  localparam int STATUS_BIT = 12;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSVD3  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSVD7  = 3'b111
  } dlvMode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  // control -> datapath strobes
  typedef struct packed {
    logic wrId;
    logic wrSpur;
    logic wrCmdHi;
    logic wrCmdLo;
    logic launch;
  } strobe_t;

  function automatic logic modeLegal(input logic [2:0] m);
    return !((m == DM_RSVD3) || (m == DM_RSVD7));
  endfunction

endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [2:0]        wrMode,
  input  logic              unitEn,
  input  logic              msgReady,
  output strobe_t           stb,
  output logic              pending,
  output logic              eoiPulse,
  output logic              busyError
);

  typedef enum logic {ST_IDLE, ST_PEND} state_e;
  state_e state, stateNext;

  logic hitId, hitSpur, hitEoi, hitLo, hitHi;
  logic busyHit;

  always_comb begin
    hitId   = (regAddr == ADDR_W'(OFF_ID));
    hitSpur = (regAddr == ADDR_W'(OFF_SPUR));
    hitEoi  = (regAddr == ADDR_W'(OFF_EOI));
    hitLo   = (regAddr == ADDR_W'(OFF_CMD_LO));
    hitHi   = (regAddr == ADDR_W'(OFF_CMD_HI));
  end

  assign pending = (state == ST_PEND);

  always_comb begin
    stb         = '0;
    stb.wrId    = regWrEn && hitId;
    stb.wrSpur  = regWrEn && hitSpur;
    stb.wrCmdHi = regWrEn && hitHi;
    stb.wrCmdLo = regWrEn && hitLo && !pending;
    stb.launch  = stb.wrCmdLo && unitEn && modeLegal(wrMode);
    busyHit     = regWrEn && hitLo && pending;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (stb.launch) stateNext = ST_PEND;
      ST_PEND: if (msgReady)   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      eoiPulse  <= 1'b0;
      busyError <= 1'b0;
    end else begin
      state     <= stateNext;
      eoiPulse  <= regWrEn && hitEoi;
      busyError <= busyHit;
    end
  end

endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPU        = 8,
  parameter int ADDR_W         = 12,
  parameter bit FORCE_SPUR_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              pending,
  output logic              unitEn,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CPU-1:0] msgRecipients,
  output logic [7:0]        msgVector,
  output logic [2:0]        msgMode,
  output logic              msgLogical,
  output logic              msgLevel,
  output logic              msgTrigger
);

  localparam logic [NUM_CPU-1:0] ALL_ONES = {NUM_CPU{1'b1}};

  logic [7:0] localId, spurVec, spurRead, destId;
  logic [7:0] cmdVec;
  logic [2:0] cmdMode;
  logic       cmdLogical, cmdLevel, cmdTrigger;
  logic [1:0] cmdShort;

  logic [NUM_CPU-1:0] selfMask, destMask, nextMask;
  logic [1:0]         wrShort;
  logic               wrLogical;

  // register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      localId    <= '0;
      spurVec    <= '0;
      unitEn     <= 1'b0;
      destId     <= '0;
      cmdVec     <= '0;
      cmdMode    <= '0;
      cmdLogical <= 1'b0;
      cmdLevel   <= 1'b0;
      cmdTrigger <= 1'b0;
      cmdShort   <= '0;
    end else begin
      if (stb.wrId) localId <= regWrData[31:24];
      if (stb.wrSpur) begin
        spurVec <= regWrData[7:0];
        unitEn  <= regWrData[8];
      end
      if (stb.wrCmdHi) destId <= regWrData[31:24];
      if (stb.wrCmdLo) begin
        cmdVec     <= regWrData[7:0];
        cmdMode    <= regWrData[10:8];
        cmdLogical <= regWrData[11];
        cmdLevel   <= regWrData[14];
        cmdTrigger <= regWrData[15];
        cmdShort   <= regWrData[19:18];
      end
    end
  end

  generate
    if (FORCE_SPUR_LOW) begin : g_spurForced
      assign spurRead = {spurVec[7:4], 4'hF};
    end else begin : g_spurPlain
      assign spurRead = spurVec;
    end
  endgenerate

  // per-processor ID match
  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpuMatch
    assign selfMask[i] = (localId == 8'(i));
    assign destMask[i] = (destId == 8'hFF) || (destId == 8'(i));
  end

  assign wrShort   = regWrData[19:18];
  assign wrLogical = regWrData[11];

  // recipient resolution uses the low word being written this cycle
  always_comb begin
    unique case (shorthand_e'(wrShort))
      SH_SELF:   nextMask = selfMask;
      SH_ALL:    nextMask = ALL_ONES;
      SH_OTHERS: nextMask = ALL_ONES & ~selfMask;
      default:   nextMask = wrLogical ? destId[NUM_CPU-1:0] : destMask;
    endcase
  end

  // message capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgRecipients <= '0;
      msgVector     <= '0;
      msgMode       <= '0;
      msgLogical    <= 1'b0;
      msgLevel      <= 1'b0;
      msgTrigger    <= 1'b0;
    end else if (stb.launch) begin
      msgRecipients <= nextMask;
      msgVector     <= regWrData[7:0];
      msgMode       <= regWrData[10:8];
      msgLogical    <= regWrData[11];
      msgLevel      <= regWrData[14];
      msgTrigger    <= regWrData[15];
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        ADDR_W'(OFF_ID):     regRdData = {localId, 24'h0};
        ADDR_W'(OFF_SPUR):   regRdData = {23'h0, unitEn, spurRead};
        ADDR_W'(OFF_CMD_HI): regRdData = {destId, 24'h0};
        ADDR_W'(OFF_CMD_LO): begin
          regRdData = {12'h0, cmdShort, 2'b00, cmdTrigger, cmdLevel, 1'b0,
                       pending, cmdLogical, cmdMode, cmdVec};
        end
        default:             regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CPU        = 8,
  parameter int ADDR_W         = 12,
  parameter bit FORCE_SPUR_LOW = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [NUM_CPU-1:0] msgRecipients,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgMode,
  output logic               msgLogical,
  output logic               msgLevel,
  output logic               msgTrigger,
  output logic               eoiPulse,
  output logic               busyError
);

  strobe_t stb;
  logic    pending;
  logic    unitEn;

  ipi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrMode    (regWrData[10:8]),
    .unitEn    (unitEn),
    .msgReady  (msgReady),
    .stb       (stb),
    .pending   (pending),
    .eoiPulse  (eoiPulse),
    .busyError (busyError)
  );

  ipi_datapath #(
    .NUM_CPU        (NUM_CPU),
    .ADDR_W         (ADDR_W),
    .FORCE_SPUR_LOW (FORCE_SPUR_LOW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .regWrData     (regWrData),
    .regRdEn       (regRdEn),
    .regAddr       (regAddr),
    .pending       (pending),
    .unitEn        (unitEn),
    .regRdData     (regRdData),
    .msgRecipients (msgRecipients),
    .msgVector     (msgVector),
    .msgMode       (msgMode),
    .msgLogical    (msgLogical),
    .msgLevel      (msgLevel),
    .msgTrigger    (msgTrigger)
  );

  assign msgValid = pending;

endmodule

// File: rtl/ipi_dispatch_checker.sv
module ipi_dispatch_checker
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regRdData,
  input logic               msgValid,
  input logic               msgReady,
  input logic [NUM_CPU-1:0] msgRecipients,
  input logic [7:0]         msgVector,
  input logic               eoiPulse,
  input logic               busyError
);

  assert_eoi_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    eoiPulse |-> $past(regWrEn && regAddr == ADDR_W'(OFF_EOI)));

  assert_eoi_reads_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(OFF_EOI)) |-> (regRdData == 32'h0));

  assert_launch_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(regWrEn && regAddr == ADDR_W'(OFF_CMD_LO)));

  assert_status_mirror_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(OFF_CMD_LO)) |-> (regRdData[STATUS_BIT] == msgValid));

  assert_handoff_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid);

  assert_busy_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    busyError |-> $past(msgValid && regWrEn && regAddr == ADDR_W'(OFF_CMD_LO)));

  assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgRecipients) && $stable(msgVector)));

endmodule

bind ipi_cmd_dispatch ipi_dispatch_checker #(
  .NUM_CPU (NUM_CPU),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regWrEn       (regWrEn),
  .regRdEn       (regRdEn),
  .regAddr       (regAddr),
  .regRdData     (regRdData),
  .msgValid      (msgValid),
  .msgReady      (msgReady),
  .msgRecipients (msgRecipients),
  .msgVector     (msgVector),
  .eoiPulse      (eoiPulse),
  .busyError     (busyError)
);

// File: tb/tb_ipi_cmd_dispatch.sv
module tb_ipi_cmd_dispatch;

  localparam int NUM_CPU = 8;
  localparam int ADDR_W  = 12;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWrEn = 1'b0;
  logic               regRdEn = 1'b0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic [31:0]        regWrData = '0;
  logic [31:0]        regRdData;
  logic               msgValid;
  logic               msgReady = 1'b0;
  logic [NUM_CPU-1:0] msgRecipients;
  logic [7:0]         msgVector;
  logic [2:0]         msgMode;
  logic               msgLogical, msgLevel, msgTrigger;
  logic               eoiPulse, busyError;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  ipi_cmd_dispatch #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .msgValid(msgValid), .msgReady(msgReady), .msgRecipients(msgRecipients),
    .msgVector(msgVector), .msgMode(msgMode), .msgLogical(msgLogical),
    .msgLevel(msgLevel), .msgTrigger(msgTrigger), .eoiPulse(eoiPulse),
    .busyError(busyError)
  );

  typedef struct packed {
    logic [7:0]  id;
    logic [7:0]  dest;
    logic [31:0] lo;
    logic [7:0]  mask;
    logic        ok;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{8'h02, 8'h05, 32'h0000_0030, 8'h20, 1'b1},  // R9 physical dest 5
    '{8'h02, 8'hFF, 32'h0000_0431, 8'hFF, 1'b1},  // R9 dest 0xFF, NMI
    '{8'h03, 8'h00, 32'h0004_0041, 8'h08, 1'b1},  // R7 self
    '{8'h03, 8'h00, 32'h0008_0500, 8'hFF, 1'b1},  // R8 all incl self
    '{8'h03, 8'h00, 32'h000C_4500, 8'hF7, 1'b1},  // R8 all excl self
    '{8'h01, 8'h0A, 32'h0000_0812, 8'h0A, 1'b1},  // R10 logical
    '{8'h04, 8'h09, 32'h0000_0020, 8'h00, 1'b1},  // R9 out-of-range dest
    '{8'h06, 8'h06, 32'h0000_0300, 8'h00, 1'b0},  // R11 mode 011
    '{8'h00, 8'h00, 32'h0000_C611, 8'h01, 1'b1},  // R5 level/trigger set
    '{8'h09, 8'h00, 32'h000C_0611, 8'hFF, 1'b1},  // R8 self id out of range
    '{8'h05, 8'h05, 32'h0000_0700, 8'h00, 1'b0}   // R11 mode 111
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn   = 1'b1;
    regAddr   = ADDR_W'(a);
    regWrData = d;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic rdReg(input int a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1;
    regAddr = ADDR_W'(a);
    #1;
    d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 msgValid", 32'(msgValid), 0);
    check("R1 eoi/busy", {30'h0, eoiPulse, busyError}, 0);
    rdReg('h020, d); check("R1 id", d, 0);
    rdReg('h0F0, d); check("R1 spur", d, 0);
    rdReg('h300, d); check("R1 cmd lo", d, 0);
    rdReg('h310, d); check("R1 cmd hi", d, 0);

    // R2 ID field only
    wrReg('h020, 32'hFFFF_FFFF);
    rdReg('h020, d); check("R2 id readback", d, 32'hFF00_0000);

    // R3 spurious / enable
    wrReg('h0F0, 32'hFFFF_F1AB);
    rdReg('h0F0, d); check("R3 spur readback", d, 32'h0000_01AB);

    // R4 EOI pulse
    wrReg('h0B0, 32'hDEAD_BEEF);
    check("R4 eoi high", 32'(eoiPulse), 1);
    @(negedge clk);
    check("R4 eoi one cycle", 32'(eoiPulse), 0);
    rdReg('h0B0, d); check("R4 eoi reads zero", d, 0);

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      wrReg('h020, {VEC[k].id, 24'h0});
      wrReg('h310, {VEC[k].dest, 24'h0});
      wrReg('h300, VEC[k].lo);
      check($sformatf("R5/R11 valid v%0d", k), 32'(msgValid), 32'(VEC[k].ok));
      if (VEC[k].ok) begin
        check($sformatf("R7-R10 mask v%0d", k), 32'(msgRecipients), 32'(VEC[k].mask));
        check($sformatf("R5 vector v%0d", k), 32'(msgVector), 32'(VEC[k].lo[7:0]));
        check($sformatf("R5 mode v%0d", k), 32'(msgMode), 32'(VEC[k].lo[10:8]));
        check($sformatf("R5 attrs v%0d", k), {29'h0, msgTrigger, msgLevel, msgLogical},
              {29'h0, VEC[k].lo[15], VEC[k].lo[14], VEC[k].lo[11]});
        rdReg('h300, d); check($sformatf("R6 status pending v%0d", k), 32'(d[12]), 1);
        accept();
        check($sformatf("R6 handoff v%0d", k), 32'(msgValid), 0);
        rdReg('h300, d); check($sformatf("R6 status idle v%0d", k), 32'(d[12]), 0);
      end else begin
        rdReg('h300, d);
        check($sformatf("R11 fields stored v%0d", k), d, VEC[k].lo & 32'h000C_CFFF);
      end
    end

    // R11 disabled unit; R6 bit 12 write ignored
    wrReg('h0F0, 32'h0000_00FF);
    wrReg('h300, 32'h0000_1030);
    check("R11 disabled no msg", 32'(msgValid), 0);
    rdReg('h300, d); check("R6 r11_ status stays idle", d, 32'h0000_0030);
    wrReg('h0F0, 32'h0000_0100);

    // R12 busy write, R13 capture
    wrReg('h020, 32'h0200_0000);
    wrReg('h310, 32'h0300_0000);
    wrReg('h300, 32'h0000_0055);
    check("R12 launched", 32'(msgValid), 1);
    wrReg('h300, 32'h0008_0066);
    check("R12 busyError high", 32'(busyError), 1);
    check("R12 vector kept", 32'(msgVector), 32'h55);
    @(negedge clk);
    check("R12 busyError one cycle", 32'(busyError), 0);
    rdReg('h300, d); check("R12 stored fields kept", d, 32'h0000_1055);
    wrReg('h310, 32'h0600_0000);
    check("R13 recipients held", 32'(msgRecipients), 32'h08);
    accept();
    check("R6 r13_ handoff", 32'(msgValid), 0);

    finishRun();
  end

endmodule